// File: doc/BRIEF.md
# LED Open-Load and Over-Temperature Fault Monitor

This block watches a bank of constant-current LED sinks for two kinds of fault and reports them on one shared, active-low error wire. Each channel has an analog comparator that says when its output node sits below the open-load threshold. A reading taken right after a channel switches on would be unreliable. So each channel waits a fixed number of system clocks after its own turn-on edge and then takes a single sample. A low node at that instant marks the channel as open. A separate over-temperature flag comes from an on-die sensor. It is brought into the clock domain through a short synchronizer.

The error pin is open-drain. The block produces only a pull-down enable, and the pad turns that enable into a low-or-floating line, so several devices can share one pulled-up wire as a wired-OR. Raising blank switches every sink off, clears and masks all open-load indications, and restarts every settling window. Over-temperature is never masked. A system controller can therefore hold blank high: if the shared line is still low, the fault is thermal. When the grayscale data latch fires, the per-channel open-load flags and the thermal bit are copied into status registers, so serial readback sees stable values.

Top module: `led_fault_monitor`

## Requirements
- R1: While reset is high, and on the first edge after it is released, `fault_pd` is 0 and `open_stat` and `therm_stat` are all zero.
- R2: A channel becomes effectively on when `ch_on[i]` is 1 and `blank` is 0. Its comparator `below_thr[i]` is sampled exactly at the SETTLE_CYCLES-th clock edge after the first edge at which it was seen effectively on. If the comparator reads 1 there, `fault_pd` goes to 1 one edge later.
- R3: The comparator is sampled once per turn-on. Values of `below_thr[i]` at any other edge, before or after the sample point, never set an open-load flag.
- R4: A channel that turns off before its sample edge takes no sample and sets no open-load flag.
- R5: While `blank` is 1, no open-load flag is set and all flags are cleared. From the first edge at which `blank` is sampled high, `fault_pd` no longer reflects any open-load flag.
- R6: `therm_in` passes through THERM_SYNC synchronizer stages and then drives `fault_pd` one edge later, whatever the value of `blank`.
- R7: `fault_pd` (1 = pull the shared error line low, 0 = release it) is the OR of the synchronized thermal flag and any unmasked open-load flag. It returns to 0 only when both are clear.
- R8: On each edge at which `latch` is 1, `open_stat[i]` takes channel i's open-load flag and `therm_stat` takes the synchronized thermal flag. Between latch edges both hold their values.
- R9: An open-load flag is held after its channel turns off. The next turn-on's sample replaces it, so a good reading clears it.
- R10: Each channel's flag appears only in its own bit of `open_stat` (bit i is channel i).

Top module ports in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_on | input | NUM_CH | Per-channel on request from the PWM engine |
| below_thr | input | NUM_CH | Per-channel comparator: output node below open-load threshold |
| blank | input | 1 | Forces all channels off, clears and masks open-load flags |
| therm_in | input | 1 | Asynchronous over-temperature flag from the sensor |
| latch | input | 1 | Grayscale latch event; captures the status registers |
| fault_pd | output | 1 | Pull-down enable for the open-drain error line (1 = drive low) |
| open_stat | output | NUM_CH | Captured per-channel open-load status |
| therm_stat | output | 1 | Captured thermal status |

## Verification
The first edge that sees a channel effectively on is counted as edge zero. The open-load flag is set at edge SETTLE_CYCLES, and `fault_pd` follows one edge after that. Each open-load check therefore samples once at SETTLE_CYCLES+1 edges, where the output must still be 0, and again at SETTLE_CYCLES+2 edges, where it must be 1. A thermal change reaches `fault_pd` THERM_SYNC+1 edges after it is applied, and the checks look on both sides of that edge. The blank mask and status capture each take effect one edge after the input is sampled. All inputs are driven, and all outputs sampled, on the falling clock edge, so every count of rising edges between stimulus and check is exact.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;
  localparam int DEF_NUM_CH     = 16;
  localparam int DEF_SETTLE     = 250;
  localparam int DEF_THERM_SYNC = 2;

  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction
endpackage

// File: rtl/lfm_chan_detect.sv
module lfm_chan_detect
  import led_fault_pkg::*;
#(
  parameter int SETTLE_CYCLES = DEF_SETTLE
) (
  input  logic clk,
  input  logic rst,
  input  logic ch_on,
  input  logic below_thr,
  input  logic blank,
  output logic open_flag
);
  localparam int CNT_W = cnt_width(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_CYCLES);

  logic             eff_on;
  logic             on_q;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign eff_on = ch_on & ~blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q      <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
      open_flag <= 1'b0;
    end else begin
      on_q <= eff_on;
      if (blank) begin
        armed     <= 1'b0;
        cnt       <= '0;
        open_flag <= 1'b0;
      end else if (eff_on && !on_q) begin
        armed <= 1'b1;
        cnt   <= CNT_W'(1);
      end else if (armed && !eff_on) begin
        armed <= 1'b0;
      end else if (armed) begin
        if (cnt == CNT_END) begin
          open_flag <= below_thr;
          armed     <= 1'b0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lfm_therm_sync.sv
module lfm_therm_sync
  import led_fault_pkg::*;
#(
  parameter int STAGES = DEF_THERM_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/lfm_fault_out.sv
module lfm_fault_out
  import led_fault_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] open_flag,
  input  logic              blank,
  input  logic              therm,
  input  logic              latch,
  output logic              fault_pd,
  output logic [NUM_CH-1:0] open_stat,
  output logic              therm_stat
);
  logic any_open;

  assign any_open = (|open_flag) & ~blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_pd   <= 1'b0;
      open_stat  <= '0;
      therm_stat <= 1'b0;
    end else begin
      fault_pd <= therm | any_open;
      if (latch) begin
        open_stat  <= open_flag;
        therm_stat <= therm;
      end
    end
  end
endmodule

// File: rtl/led_fault_monitor.sv
module led_fault_monitor
  import led_fault_pkg::*;
#(
  parameter int NUM_CH        = DEF_NUM_CH,
  parameter int SETTLE_CYCLES = DEF_SETTLE,
  parameter int THERM_SYNC    = DEF_THERM_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_on,
  input  logic [NUM_CH-1:0] below_thr,
  input  logic              blank,
  input  logic              therm_in,
  input  logic              latch,
  output logic              fault_pd,
  output logic [NUM_CH-1:0] open_stat,
  output logic              therm_stat
);
  logic [NUM_CH-1:0] open_flag;
  logic              therm_q;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      lfm_chan_detect #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_det (
        .clk       (clk),
        .rst       (rst),
        .ch_on     (ch_on[i]),
        .below_thr (below_thr[i]),
        .blank     (blank),
        .open_flag (open_flag[i])
      );
    end
  endgenerate

  lfm_therm_sync #(.STAGES(THERM_SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (therm_in),
    .q   (therm_q)
  );

  lfm_fault_out #(.NUM_CH(NUM_CH)) u_out (
    .clk        (clk),
    .rst        (rst),
    .open_flag  (open_flag),
    .blank      (blank),
    .therm      (therm_q),
    .latch      (latch),
    .fault_pd   (fault_pd),
    .open_stat  (open_stat),
    .therm_stat (therm_stat)
  );
endmodule

// File: rtl/led_fault_monitor_chk.sv
module led_fault_monitor_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              blank,
  input logic              latch,
  input logic              therm_q,
  input logic [NUM_CH-1:0] open_flag,
  input logic              fault_pd,
  input logic [NUM_CH-1:0] open_stat,
  input logic              therm_stat
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!fault_pd && open_stat == '0 && !therm_stat));

  a_r5_blank_clears: assert property (@(posedge clk) disable iff (rst)
    blank |=> (open_flag == '0));

  a_r5_blank_masks: assert property (@(posedge clk) disable iff (rst)
    (blank && !therm_q) |=> !fault_pd);

  a_r6_therm_unmasked: assert property (@(posedge clk) disable iff (rst)
    therm_q |=> fault_pd);

  a_r7_open_reported: assert property (@(posedge clk) disable iff (rst)
    ((open_flag != '0) && !blank) |=> fault_pd);

  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    latch |=> (open_stat == $past(open_flag) && therm_stat == $past(therm_q)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !latch |=> ($stable(open_stat) && $stable(therm_stat)));
endmodule

bind led_fault_monitor led_fault_monitor_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .blank      (blank),
  .latch      (latch),
  .therm_q    (therm_q),
  .open_flag  (open_flag),
  .fault_pd   (fault_pd),
  .open_stat  (open_stat),
  .therm_stat (therm_stat)
);

// File: tb/led_fault_monitor_tb.sv
`timescale 1ns/1ps
module led_fault_monitor_tb;
  localparam int N  = 16;
  localparam int S  = 6;
  localparam int TS = 2;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] ch_on, below_thr;
  logic         blank, therm_in, latch;
  logic         fault_pd, therm_stat;
  logic [N-1:0] open_stat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  led_fault_monitor #(.NUM_CH(N), .SETTLE_CYCLES(S), .THERM_SYNC(TS)) u_dut (
    .clk(clk), .rst(rst), .ch_on(ch_on), .below_thr(below_thr),
    .blank(blank), .therm_in(therm_in), .latch(latch),
    .fault_pd(fault_pd), .open_stat(open_stat), .therm_stat(therm_stat)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    ch_on = '0; below_thr = '0; latch = 1'b0; blank = 1'b1;
    tick(1);
    blank = 1'b0;
    tick(1);
  endtask

  task automatic do_latch();
    latch = 1'b1;
    tick(1);
    latch = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; ch_on = '0; below_thr = '0; blank = 1'b0; therm_in = 1'b0; latch = 1'b0;
    tick(3);
    chk(N'(fault_pd), '0, "R1 fault_pd in reset");
    rst = 1'b0;
    tick(1);
    chk(open_stat, '0, "R1 open_stat after reset");
    chk(N'(therm_stat), '0, "R1 therm_stat after reset");
    chk(N'(fault_pd), '0, "R1 fault_pd after reset");
  endtask

  task automatic t_r2_sample_point();
    ch_on[5] = 1'b1; below_thr[5] = 1'b1;
    tick(S + 1);
    chk(N'(fault_pd), '0, "R2 no fault before sample+1");
    tick(1);
    chk(N'(fault_pd), N'(1), "R2 fault one edge after sample");
    clear_all();
  endtask

  task automatic t_r3_off_sample();
    ch_on[7] = 1'b1; below_thr[7] = 1'b1;
    tick(S);
    below_thr[7] = 1'b0;
    tick(1);
    below_thr[7] = 1'b1;
    tick(S + 3);
    chk(N'(fault_pd), '0, "R3 comparator outside sample edge ignored");
    clear_all();
  endtask

  task automatic t_r4_early_off();
    ch_on[1] = 1'b1; below_thr[1] = 1'b1;
    tick(S);
    ch_on[1] = 1'b0;
    tick(S + 3);
    chk(N'(fault_pd), '0, "R4 early turn-off takes no sample");
    clear_all();
  endtask

  task automatic t_r5_blank();
    ch_on[0] = 1'b1; below_thr[0] = 1'b1;
    tick(S + 2);
    chk(N'(fault_pd), N'(1), "R5 setup open fault");
    blank = 1'b1;
    tick(1);
    chk(N'(fault_pd), '0, "R5 blank masks open-load at once");
    tick(S + 3);
    chk(N'(fault_pd), '0, "R5 no detection while blank");
    ch_on[0] = 1'b0;
    tick(1);
    blank = 1'b0;
    tick(2);
    chk(N'(fault_pd), '0, "R5 flag cleared after blank");
    clear_all();
  endtask

  task automatic t_r9_resample();
    ch_on[3] = 1'b1; below_thr[3] = 1'b1;
    tick(S + 2);
    chk(N'(fault_pd), N'(1), "R9 first sample flags");
    ch_on[3] = 1'b0;
    tick(3);
    chk(N'(fault_pd), N'(1), "R9 flag held while off");
    ch_on[3] = 1'b1; below_thr[3] = 1'b0;
    tick(S + 1);
    chk(N'(fault_pd), N'(1), "R9 old flag until resample");
    tick(1);
    chk(N'(fault_pd), '0, "R9 good resample clears");
    clear_all();
  endtask

  task automatic t_r8_r10_status();
    ch_on = '1; below_thr = 16'h2004;
    tick(S + 2);
    chk(N'(fault_pd), N'(1), "R10 fault from two channels");
    do_latch();
    chk(open_stat, 16'h2004, "R10 R8 per-channel status bits");
    clear_all();
    tick(2);
    chk(open_stat, 16'h2004, "R8 status stable without latch");
    do_latch();
    chk(open_stat, '0, "R8 latch captures cleared flags");
  endtask

  task automatic t_r6_r7_therm();
    blank = 1'b1; therm_in = 1'b1;
    tick(TS);
    chk(N'(fault_pd), '0, "R6 thermal not yet through sync");
    tick(1);
    chk(N'(fault_pd), N'(1), "R6 thermal unmasked by blank");
    do_latch();
    chk(N'(therm_stat), N'(1), "R6 R8 thermal status captured");
    therm_in = 1'b0; blank = 1'b0;
    tick(TS + 1);
    chk(N'(fault_pd), '0, "R7 released when both clear");
    ch_on[9] = 1'b1; below_thr[9] = 1'b1;
    tick(S + 2);
    therm_in = 1'b1;
    tick(5);
    chk(N'(fault_pd), N'(1), "R7 OR of thermal and open");
    therm_in = 1'b0;
    tick(5);
    chk(N'(fault_pd), N'(1), "R7 open keeps line low");
    blank = 1'b1;
    tick(1);
    chk(N'(fault_pd), '0, "R7 release after open masked");
    clear_all();
  endtask

  initial begin
    t_reset();
    t_r2_sample_point();
    t_r3_off_sample();
    t_r4_early_off();
    t_r5_blank();
    t_r9_resample();
    t_r8_r10_status();
    t_r6_r7_therm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule